// File: doc/BRIEF.md
# Chip-Select Output Controller

This block drives a bank of general-purpose output pins that can serve as SPI chip selects. Each pin has an output latch and two configuration bits: a select-mode flag, which is passed out to steer the pad toward its chip-select function, and an invert flag that flips the latch value on its way to the pin.

Software changes latches through a write-only strobe register. The upper half sets latches and the lower half clears them, so one pin can be changed without a read-modify-write. Because the pin level is the latch XOR its invert bit, an active-high device is selected by clearing its latch while its invert bit is set. A register write port reaches the configuration and strobe registers. A combinational read port returns the configuration, or the current pin levels.

Logical select numbers map to pins by subtracting a base offset, which is 1 by default. Software applies this mapping and the hardware sees only pin indices.

Top module: `cs_out_ctrl`

## Requirements
- R1: After reset the configuration register is 0, every output latch is 1, `pin_out` is all ones and `pin_cs_mode` is all zeros.
- R2: A write to address 0 (configuration) stores data bits [15:8] as the per-pin select-mode flags, which appear on `pin_cs_mode`, and data bits [7:0] as the per-pin invert flags. Reading address 0 returns {mode, invert}.
- R3: A write to address 1 (strobe) with data bit n+8 set drives latch n to 1.
- R4: A write to address 1 with data bit n set and bit n+8 clear drives latch n to 0.
- R5: Latches whose set and clear bits are both 0 in a strobe write keep their value.
- R6: When the set bit and the clear bit of the same pin are both 1 in one strobe write, the set takes priority and the latch becomes 1.
- R7: `pin_out[n]` equals latch n XOR invert flag n. It follows a register write on the clock edge that performs the write.
- R8: Reading address 2 (status) returns the pin levels in bits [7:0] and zeros in bits [15:8]. Reading address 1 returns 0.
- R9: Writing 0 to the configuration register returns every pin to non-inverted mode, so `pin_out` equals the latches and `pin_cs_mode` is 0.
- R10: With invert flag n set, clearing latch n drives `pin_out[n]` high. This asserts an active-high select.
- R11: A write to address 3, or any cycle with `wr_en` low, changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 configuration, 1 strobe |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 configuration, 1 strobe (reads 0), 2 status |
| rd_data | output | 16 | Combinational read data |
| pin_out | output | 8 | Pin levels after inversion |
| pin_cs_mode | output | 8 | Per-pin chip-select mode flags |

## Verification
Setting and clearing the same latch can fall in the same cycle when one strobe word carries both bits for one pin. The bench first clears a pin, then writes a word with both of its bits set, and expects the pin to follow a latch value of 1. The same word also carries unrelated zero bits, whose pins must keep their values. A reference model built from the requirements sits in the scoreboard queue and judges every write one clock after it is issued.

// File: rtl/cs_out_pkg.sv
package cs_out_pkg;
    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CFG    = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STROBE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg #(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [2*NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0]   mode,
    output logic [NUM_PINS-1:0]   inv
);
    typedef struct packed {
        logic [NUM_PINS-1:0] mode;
        logic [NUM_PINS-1:0] inv;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.mode = wdata[2*NUM_PINS-1:NUM_PINS];
            cfg_d.inv  = wdata[NUM_PINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode = cfg_q.mode;
    assign inv  = cfg_q.inv;
endmodule

// File: rtl/cs_latch_bank.sv
module cs_latch_bank #(
    parameter int unsigned NUM_PINS = 8,
    parameter logic [NUM_PINS-1:0] LATCH_INIT = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [NUM_PINS-1:0] set_mask,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] latch
);
    typedef struct packed {
        logic [NUM_PINS-1:0] bits;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_PINS-1:0] pin_next;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_comb begin
            if (set_mask[i])      pin_next[i] = 1'b1;
            else if (clr_mask[i]) pin_next[i] = 1'b0;
            else                  pin_next[i] = bank_q.bits[i];
        end
    end

    always_comb begin
        bank_d = bank_q;
        if (we) bank_d.bits = pin_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q.bits <= LATCH_INIT;
        else        bank_q      <= bank_d;
    end

    assign latch = bank_q.bits;
endmodule

// File: rtl/cs_pin_drive.sv
module cs_pin_drive #(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0] latch,
    input  logic [NUM_PINS-1:0] inv,
    input  logic [NUM_PINS-1:0] mode,
    output logic [NUM_PINS-1:0] pin_level,
    output logic [NUM_PINS-1:0] pin_mode
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_drv
        assign pin_level[i] = latch[i] ^ inv[i];
        assign pin_mode[i]  = mode[i];
    end
endmodule

// File: rtl/cs_out_ctrl.sv
module cs_out_ctrl
    import cs_out_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    localparam int unsigned DATA_W = 2 * NUM_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_cs_mode
);
    logic cfg_we, strobe_we;
    logic [NUM_PINS-1:0] mode_vec, inv_vec, latch_vec;

    assign cfg_we    = wr_en && (wr_addr == ADDR_CFG);
    assign strobe_we = wr_en && (wr_addr == ADDR_STROBE);

    cs_cfg_reg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (wr_data),
        .mode  (mode_vec),
        .inv   (inv_vec)
    );

    cs_latch_bank #(.NUM_PINS(NUM_PINS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (strobe_we),
        .set_mask (wr_data[DATA_W-1:NUM_PINS]),
        .clr_mask (wr_data[NUM_PINS-1:0]),
        .latch    (latch_vec)
    );

    cs_pin_drive #(.NUM_PINS(NUM_PINS)) u_drive (
        .latch     (latch_vec),
        .inv       (inv_vec),
        .mode      (mode_vec),
        .pin_level (pin_out),
        .pin_mode  (pin_cs_mode)
    );

    always_comb begin
        unique case (rd_addr)
            ADDR_CFG:    rd_data = {mode_vec, inv_vec};
            ADDR_STATUS: rd_data = {{NUM_PINS{1'b0}}, pin_out};
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cs_out_ctrl_chk.sv
module cs_out_ctrl_chk
    import cs_out_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [2*NUM_PINS-1:0] wr_data,
    input logic [ADDR_W-1:0]     rd_addr,
    input logic [2*NUM_PINS-1:0] rd_data,
    input logic [NUM_PINS-1:0]   pin_out,
    input logic [NUM_PINS-1:0]   pin_cs_mode,
    input logic [NUM_PINS-1:0]   latch_vec,
    input logic [NUM_PINS-1:0]   inv_vec
);
    logic stb, cfg;
    assign stb = wr_en && (wr_addr == ADDR_STROBE);
    assign cfg = wr_en && (wr_addr == ADDR_CFG);

    p_cfg_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg |=> (pin_cs_mode == $past(wr_data[2*NUM_PINS-1:NUM_PINS]))
                && (inv_vec == $past(wr_data[NUM_PINS-1:0])));

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> ((latch_vec & $past(wr_data[2*NUM_PINS-1:NUM_PINS]))
                 == $past(wr_data[2*NUM_PINS-1:NUM_PINS])));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> ((latch_vec & $past(wr_data[NUM_PINS-1:0]
                 & ~wr_data[2*NUM_PINS-1:NUM_PINS])) == '0));

    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (((latch_vec ^ $past(latch_vec))
                 & ~$past(wr_data[NUM_PINS-1:0] | wr_data[2*NUM_PINS-1:NUM_PINS])) == '0));

    p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_STATUS) |-> (rd_data == {{NUM_PINS{1'b0}}, pin_out}));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pin_out) && $stable(pin_cs_mode)));
endmodule

bind cs_out_ctrl cs_out_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .pin_out     (pin_out),
    .pin_cs_mode (pin_cs_mode),
    .latch_vec   (latch_vec),
    .inv_vec     (inv_vec)
);

// File: tb/tb_cs_out_ctrl.sv
module tb_cs_out_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk, rst_n, wr_en;
    logic [1:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic [7:0]  pin_out, pin_cs_mode;

    cs_out_ctrl #(.NUM_PINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_out(pin_out), .pin_cs_mode(pin_cs_mode)
    );

    typedef struct {
        logic [7:0] pins;
        logic [7:0] mode;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] m_latch, m_inv, m_mode;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor: compare the output one edge after each queued write
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            check({e.tag, " pins"}, {8'h00, pin_out}, {8'h00, e.pins});
            check({e.tag, " mode"}, {8'h00, pin_cs_mode}, {8'h00, e.mode});
        end
    end

    // Driver: issue a write and push the model's expectation
    task automatic wr(input logic [1:0] a, input logic [15:0] d, input string tag);
        exp_t x;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (a == 2'd0) begin
            m_mode = d[15:8];
            m_inv  = d[7:0];
        end else if (a == 2'd1) begin
            m_latch = (m_latch & ~d[7:0]) | d[15:8];
        end
        x.pins = m_latch ^ m_inv;
        x.mode = m_mode;
        x.tag  = tag;
        q.push_back(x);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [15:0] expv, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, expv);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        m_latch = 8'hFF; m_inv = 8'h00; m_mode = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, 16'h0000, "R1 cfg");
        check("R1 pins", {8'h00, pin_out}, 16'h00FF);
        check("R1 mode", {8'h00, pin_cs_mode}, 16'h0000);

        // R2 / R7 configuration store and inversion
        wr(2'd0, 16'hA50F, "R2 R7 cfg");
        rd(2'd0, 16'hA50F, "R2 readback");

        // R4 clear, R3 set
        wr(2'd1, 16'h0003, "R4 clear");
        wr(2'd1, 16'h0100, "R3 set");
        // R5 empty strobe
        wr(2'd1, 16'h0000, "R5 none");
        // R6 collision: clear pin2, then set+clear together
        wr(2'd1, 16'h0004, "R4 clear2");
        wr(2'd1, 16'h0404, "R6 collide");
        check("R6 pin2", {15'h0, pin_out[2]}, {15'h0, ~m_inv[2]});

        // R8 readback
        rd(2'd2, {8'h00, m_latch ^ m_inv}, "R8 status");
        rd(2'd1, 16'h0000, "R8 strobe");

        // R11 unmapped write and idle data
        wr(2'd3, 16'hFFFF, "R11 addr3");
        @(negedge clk);
        wr_data = 16'h00FF; wr_addr = 2'd1;
        @(negedge clk);
        check("R11 idle", {8'h00, pin_out}, {8'h00, m_latch ^ m_inv});

        // R10 active-high select on pin5
        wr(2'd0, 16'h0020, "R10 cfg");
        wr(2'd1, 16'h2000, "R10 setlatch");
        check("R10 deassert", {15'h0, pin_out[5]}, 16'h0000);
        wr(2'd1, 16'h0020, "R10 clear");
        check("R10 assert", {15'h0, pin_out[5]}, 16'h0001);

        // R9 restore plain mode
        wr(2'd0, 16'h0000, "R9 cfg0");
        check("R9 pins", {8'h00, pin_out}, {8'h00, m_latch});
        wr(2'd1, 16'hFF00, "R3 all high");

        repeat (3) @(negedge clk);
        check("scoreboard drained", 16'(q.size()), 16'h0000);
        finish_run();
    end
endmodule